// File: doc/BRIEF.md
# Packed FIFO word sample unpacker

This block sits between a playback FIFO that delivers 64-bit words and a serial audio shifter that consumes one sample at a time. Each FIFO word carries several audio samples packed side by side. A three-bit format code chooses the packing: eight 8-bit samples, four 16-bit samples or two 32-bit samples per word. The block hands the samples out one by one, from the least significant container upward. Each sample is widened to the output width and placed against the most significant bit with zeros below it, so the shifter can send it MSB first. Each sample also carries its position inside the word.

Both data sides use a valid/ready handshake. On the word side, a word is taken only when `word_ready_o` is high while `word_valid_i` is high. The block raises `word_ready_o` only in the cycle where the sample side accepts the final sample of the current word. The FIFO must therefore hold the word and its format code steady until that cycle. On the sample side, `smp_valid_o` follows `word_valid_i`. While `smp_ready_i` stays low, the presented sample, its index and the word are all held. A format code the block does not support yields no samples. The word is discarded in the same cycle and `type_err_o` is raised for that cycle, so the stream never stalls.

Top module: `fifo_word_unpacker`

## Requirements
- R1: Out of reset, with no word offered, `smp_valid_o`, `word_ready_o` and `type_err_o` are low. The first sample of the first word has index 0.
- R2: With format code 0, sample k (k = 0..7) is word bits [8k+7:8k]. It appears on `smp_data_o[31:24]` with bits [23:0] zero.
- R3: With format code 2, sample k (k = 0..3) is word bits [16k+15:16k]. It appears on `smp_data_o[31:16]` with bits [15:0] zero.
- R4: With format code 4, sample k (k = 0..1) is word bits [32k+31:32k] and fills `smp_data_o` entirely.
- R5: Samples leave in ascending container order. `smp_idx_o` starts at 0 for every word and rises by one per accepted sample.
- R6: For a supported code, `word_ready_o` is high only in the cycle where `smp_valid_o`, `smp_ready_i` and index = last index of the word are all high. After that cycle the next word starts at index 0.
- R7: While `smp_valid_o` is high and `smp_ready_i` is low, the sample data and index stay unchanged into the next cycle.
- R8: Codes 1, 3, 5, 6 and 7 are unsupported. With such a word offered, `smp_valid_o` is low, while `type_err_o` and `word_ready_o` are high in that same cycle.
- R9: `smp_valid_o` is never high while `word_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid_i | input | 1 | FIFO word available |
| word_data_i | input | 64 | Packed FIFO word |
| word_fmt_i | input | 3 | Packing code (0, 2, 4 supported) |
| word_ready_o | output | 1 | Word consumed this cycle |
| smp_valid_o | output | 1 | Sample available |
| smp_data_o | output | 32 | MSB-aligned sample, zero filled |
| smp_idx_o | output | 3 | Container index of the sample in its word |
| smp_ready_i | input | 1 | Downstream accepts the sample |
| type_err_o | output | 1 | Unsupported code seen on an offered word |

## Verification
The bench targets three handoff points. The first is the final sample of a word. A design that pops the word one sample early or late either loses the top container or repeats it, and the next word starts at a nonzero index. The second is back-pressure arriving on a last sample. An index that advances while the downstream stalls skips a sample, and a word popped under a stall drops the sample. The third is unsupported codes mixed between good words. A design that stalls there hangs the stream. One that emits samples for a bad code, or carries a stale index into the next word, shows wrong data or wrong indices on the following samples.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int CODE_W = 3;
  localparam int IDX_W  = 3;

  typedef struct packed {
    logic             ok;
    logic [1:0]       size_lg;   // 0: 8-bit, 1: 16-bit, 2: 32-bit
    logic [IDX_W-1:0] last_idx;
  } pk_fmt_t;

  function automatic pk_fmt_t pk_decode(input logic [CODE_W-1:0] code);
    pk_fmt_t f;
    f = '0;
    case (code)
      3'd0: begin f.ok = 1'b1; f.size_lg = 2'd0; f.last_idx = 3'd7; end
      3'd2: begin f.ok = 1'b1; f.size_lg = 2'd1; f.last_idx = 3'd3; end
      3'd4: begin f.ok = 1'b1; f.size_lg = 2'd2; f.last_idx = 3'd1; end
      default: f = '0;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/unpk_slot_ctr.sv
module unpk_slot_ctr
  import unpk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (adv_i)  idx_q <= (idx_q == last_i) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  // R5: an accepted non-final sample moves the index up by exactly one
  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && idx_q != last_i) |=> idx_q == $past(idx_q) + 1'b1);

  // R6: accepting the final sample restarts the count
  p_idx_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && idx_q == last_i) |=> idx_q == '0);
endmodule

// File: rtl/unpk_lane_sel.sv
module unpk_lane_sel #(
  parameter int WORD_W = 64,
  parameter int OUT_W  = 32,
  parameter int IDX_W  = 3
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        size_lg_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [OUT_W-1:0]  smp_o
);
  localparam int N8  = WORD_W / 8;
  localparam int N16 = WORD_W / 16;
  localparam int N32 = WORD_W / 32;
  localparam int S16 = $clog2(N16);
  localparam int S32 = (N32 > 1) ? $clog2(N32) : 1;

  logic [7:0]  l8  [N8];
  logic [15:0] l16 [N16];
  logic [31:0] l32 [N32];

  for (genvar g = 0; g < N8; g++) begin : g_b8
    assign l8[g] = word_i[8*g +: 8];
  end
  for (genvar g = 0; g < N16; g++) begin : g_h16
    assign l16[g] = word_i[16*g +: 16];
  end
  for (genvar g = 0; g < N32; g++) begin : g_w32
    assign l32[g] = word_i[32*g +: 32];
  end

  always_comb begin
    case (size_lg_i)
      2'd0:    smp_o = {l8[idx_i], {(OUT_W-8){1'b0}}};
      2'd1:    smp_o = {l16[idx_i[S16-1:0]], {(OUT_W-16){1'b0}}};
      2'd2:    smp_o = {l32[idx_i[S32-1:0]], {(OUT_W-32){1'b0}}};
      default: smp_o = '0;
    endcase
  end
endmodule

// File: rtl/fifo_word_unpacker.sv
module fifo_word_unpacker
  import unpk_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int OUT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  input  logic [CODE_W-1:0] word_fmt_i,
  output logic              word_ready_o,
  output logic              smp_valid_o,
  output logic [OUT_W-1:0]  smp_data_o,
  output logic [IDX_W-1:0]  smp_idx_o,
  input  logic              smp_ready_i,
  output logic              type_err_o
);
  pk_fmt_t          fmt;
  logic             take;
  logic [IDX_W-1:0] idx;

  assign fmt         = pk_decode(word_fmt_i);
  assign smp_valid_o = word_valid_i && fmt.ok;
  assign type_err_o  = word_valid_i && !fmt.ok;
  assign take        = smp_valid_o && smp_ready_i;
  assign word_ready_o = type_err_o || (take && idx == fmt.last_idx);
  assign smp_idx_o   = idx;

  unpk_slot_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (take),
    .last_i (fmt.last_idx),
    .idx_o  (idx)
  );

  unpk_lane_sel #(.WORD_W(WORD_W), .OUT_W(OUT_W), .IDX_W(IDX_W)) u_sel (
    .word_i    (word_data_i),
    .size_lg_i (fmt.size_lg),
    .idx_i     (idx),
    .smp_o     (smp_data_o)
  );

  // R7: a stalled sample keeps its data and index
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && !smp_ready_i && word_valid_i) |=>
      (!word_valid_i || ($stable(smp_idx_o) && $stable(smp_data_o))));

  // R8: a bad code never produces a sample
  p_bad_no_smp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    type_err_o |-> (!smp_valid_o && word_ready_o));

  // R9: no sample without a word
  p_no_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_i |-> !smp_valid_o);

  // R6: after a pop the next sample starts at index 0
  p_pop_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready_o |=> smp_idx_o == '0);
endmodule

// File: tb/fifo_word_unpacker_test.sv
`timescale 1ns/1ps
module fifo_word_unpacker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [63:0] word_data_i = '0;
  logic [2:0]  word_fmt_i = '0;
  logic        word_ready_o, smp_valid_o, smp_ready_i, type_err_o;
  logic [31:0] smp_data_o;
  logic [2:0]  smp_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_word_unpacker uut (
    .clk(clk), .rst_n(rst_n), .word_valid_i(word_valid_i),
    .word_data_i(word_data_i), .word_fmt_i(word_fmt_i),
    .word_ready_o(word_ready_o), .smp_valid_o(smp_valid_o),
    .smp_data_o(smp_data_o), .smp_idx_o(smp_idx_o),
    .smp_ready_i(smp_ready_i), .type_err_o(type_err_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int fmt_seq [14] = '{0, 2, 4, 1, 0, 2, 4, 3, 2, 4, 0, 5, 6, 7};
    bit          have = 0;
    int          exp_idx = 0;
    int          nwords = 0;
    int          w, n;
    bit          ok, e_sv, e_err, e_wr, prev_stall;
    longint      e_data;
    string       dtag;
    smp_ready_i = 1'b0;
    prev_stall = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 smp_valid", smp_valid_o, 0);
    chk("R1 word_ready", word_ready_o, 0);
    chk("R1 type_err", type_err_o, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (!have && ($urandom % 4 != 0)) begin
        have = 1;
        word_data_i = {$urandom, $urandom};
        word_fmt_i = 3'(fmt_seq[nwords % 14]);
        nwords++;
      end
      if (!have) word_fmt_i = 3'($urandom);
      word_valid_i = have;
      smp_ready_i = ($urandom % 3 != 0);
      #1;
      ok = (word_fmt_i == 0) || (word_fmt_i == 2) || (word_fmt_i == 4);
      w = 8 << (word_fmt_i / 2);
      n = 64 / w;
      e_sv = have && ok;
      e_err = have && !ok;
      e_wr = e_err || (e_sv && smp_ready_i && exp_idx == n - 1);
      chk(have ? "R8 smp_valid" : "R9 smp_valid", smp_valid_o, e_sv);
      chk("R8 type_err", type_err_o, e_err);
      chk("R6 word_ready", word_ready_o, e_wr);
      if (e_sv) begin
        e_data = longint'(((word_data_i >> (w * exp_idx)) &
                           ((64'd1 << w) - 64'd1)) << (32 - w)) & 64'hFFFF_FFFF;
        dtag = (w == 8) ? "R2 data" : (w == 16) ? "R3 data" : "R4 data";
        chk(prev_stall ? "R7 data" : dtag, smp_data_o, e_data);
        chk(prev_stall ? "R7 idx" : "R5 idx", smp_idx_o, exp_idx);
      end
      prev_stall = e_sv && !smp_ready_i;
      if (e_sv && smp_ready_i) begin
        if (exp_idx == n - 1) begin exp_idx = 0; have = 0; end
        else exp_idx++;
      end
      if (e_err) have = 0;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule